// File: doc/BRIEF.md
# SPI-Format Master Serial Port

This block is a master-mode synchronous serial port that moves one word at a time in SPI format. Software-side logic writes a small register set to choose a bit-rate divisor, a word length of 4 to 16 bits, the clock source, the idle level and phase of the serial clock, an internal loop-back path and two interrupt enables. A word written to the data register starts a frame. The block drops an active-low frame select, shifts the word out most significant bit first on the serial data output, and shifts a word in from the serial data input. At the end of the frame the received word lands in a receive holding register.

The serial clock comes from a divider. One of two source strobes, an internal reference strobe or an external one, is chosen by a control bit. The divider turns that strobe into half bit periods of rate+1 source strobes each, so one bit period is the source rate divided by 2 and then by rate+1. The phase bit selects where the clock stays idle inside the frame: one full bit period after frame select falls and half a period before it rises, or the reverse. Settings written during a frame are applied from the next frame start.

Top module: `spi_master_port`

## Requirements
- R1: After synchronous reset, fsel_n is 1, sclk and txd are 0, both interrupts are 0, the CTRL (address 0) and MODE (address 1) registers read 0, and STAT (address 3) reads 0x0001.
- R2: With the internal source strobe high on every cycle, a half bit period lasts rate+1 cycles, where rate is CTRL bits 7:0, and a frame of N bits holds fsel_n low for (2N+2)(rate+1) cycles.
- R3: CTRL bit 12 set to 1 makes the divider count ext_tick strobes and ignore ref_tick; set to 0, it counts ref_tick strobes.
- R4: Outside a frame, sclk rests at the level of MODE bit 3 (0 = idle low, 1 = idle high).
- R5: With MODE bit 4 (phase) at 0, the first sclk edge comes two half periods after fsel_n falls and fsel_n rises one half period after the last edge. With phase at 1, these are one and two half periods. Every frame has exactly 2N sclk edges.
- R6: Data is sent most significant bit first. With phase 0, the incoming bit is sampled on each idle-to-active sclk edge and txd changes on active-to-idle edges. With phase 1, txd changes on active-to-idle... reversed: txd changes on idle-to-active edges and the incoming bit is sampled on active-to-idle edges. txd changes only when sclk changes.
- R7: The word length N is CTRL bits 11:8 plus 1 for field values 3 to 15; values 0 to 2 give N = 4. The received word is right-aligned in DATA (address 2) with zeros above bit N-1, and only the low N bits of the written word are sent.
- R8: With MODE bit 2 set, the receive shifter takes its input from the transmit shifter output, and the rxd pin has no effect on the received word.
- R9: irq_tx is high when MODE bit 1 is set and the transmit holding register is empty (STAT bit 0). irq_rx is high when MODE bit 0 is set and a received word is waiting (STAT bit 1). That flag is set at frame end and cleared by a read of DATA with reg_re.
- R10: Writes to CTRL or MODE while fsel_n is low change neither the rate, length, polarity nor phase of the frame in progress. They apply from the next frame start.
- R11: fsel_n stays low for the whole frame. When a new word is already held at frame end, the next frame begins on the cycle after fsel_n rises, leaving fsel_n high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a DATA read clears the receive flag) |
| reg_addr | input | 2 | Register select: 0 CTRL, 1 MODE, 2 DATA, 3 STAT |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| ref_tick | input | 1 | Internal reference source strobe |
| ext_tick | input | 1 | External source strobe |
| rxd | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock |
| txd | output | 1 | Serial data output |
| fsel_n | output | 1 | Active-low frame select |
| irq_tx | output | 1 | Transmit-service interrupt |
| irq_rx | output | 1 | Receive-service interrupt |

## Verification
The bench goes after the idle-time placement for both phase settings. A design with the phase sense inverted shows the wrong lead and trail times and samples a bit early, which corrupts the received word. It also covers the divider's rate+1 count, where an off-by-one shows up as wrong frame lengths, and word lengths at the clamped minimum and at 16 bits, where a wrong left-alignment sends low bits first. Loop-back is run with a conflicting rxd stream, settings are rewritten mid-frame, and two words are queued back to back. These catch a design that reads the pin in loop-back, reconfigures a live frame, or wastes idle cycles between frames.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int RATE_W   = 8;
    localparam int SIZE_W   = 4;
    localparam int MAX_BITS = 16;
    localparam int MIN_BITS = 4;
    localparam int REG_W    = 16;
    localparam int BITS_W   = $clog2(MAX_BITS + 1);
    localparam int CNT_W    = BITS_W + 1;

    localparam int CTRL_EXT_BIT = RATE_W + SIZE_W;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [SIZE_W-1:0] size_m1;
        logic              ext_sel;
        logic              cpol;
        logic              cpha;
        logic              loopback;
    } frame_cfg_t;

    function automatic logic [BITS_W-1:0] frame_bits(input logic [SIZE_W-1:0] f);
        if (f < SIZE_W'(MIN_BITS - 1))
            return BITS_W'(MIN_BITS);
        else
            return BITS_W'(f) + BITS_W'(1);
    endfunction

endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
    import spi_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                take,
    input  logic                done,
    input  logic                busy,
    input  logic [MAX_BITS-1:0] rx_word,
    output frame_cfg_t          cfg,
    output logic                tx_full,
    output logic [MAX_BITS-1:0] tx_word,
    output logic                irq_tx,
    output logic                irq_rx
);

    logic [RATE_W-1:0]   rate_q;
    logic [SIZE_W-1:0]   size_q;
    logic                ext_q;
    logic                rie_q, tie_q, loop_q, cpol_q, cpha_q;
    logic                rx_full_q;
    logic [MAX_BITS-1:0] rx_q;
    reg_addr_e           addr;

    assign addr = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q    <= '0;
            size_q    <= '0;
            ext_q     <= 1'b0;
            rie_q     <= 1'b0;
            tie_q     <= 1'b0;
            loop_q    <= 1'b0;
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
            tx_full   <= 1'b0;
            tx_word   <= '0;
            rx_full_q <= 1'b0;
            rx_q      <= '0;
        end else begin
            if (take)
                tx_full <= 1'b0;
            if (reg_we) begin
                unique case (addr)
                    ADDR_CTRL: begin
                        rate_q <= reg_wdata[RATE_W-1:0];
                        size_q <= reg_wdata[RATE_W +: SIZE_W];
                        ext_q  <= reg_wdata[CTRL_EXT_BIT];
                    end
                    ADDR_MODE: begin
                        rie_q  <= reg_wdata[0];
                        tie_q  <= reg_wdata[1];
                        loop_q <= reg_wdata[2];
                        cpol_q <= reg_wdata[3];
                        cpha_q <= reg_wdata[4];
                    end
                    ADDR_DATA: begin
                        tx_word <= reg_wdata[MAX_BITS-1:0];
                        tx_full <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (reg_re && addr == ADDR_DATA)
                rx_full_q <= 1'b0;
            if (done) begin
                rx_q      <= rx_word;
                rx_full_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: reg_rdata = REG_W'({ext_q, size_q, rate_q});
            ADDR_MODE: reg_rdata = REG_W'({cpha_q, cpol_q, loop_q, tie_q, rie_q});
            ADDR_DATA: reg_rdata = REG_W'(rx_q);
            default:   reg_rdata = REG_W'({busy, rx_full_q, ~tx_full});
        endcase
    end

    always_comb begin
        cfg.rate     = rate_q;
        cfg.size_m1  = size_q;
        cfg.ext_sel  = ext_q;
        cfg.cpol     = cpol_q;
        cfg.cpha     = cpha_q;
        cfg.loopback = loop_q;
    end

    assign irq_tx = tie_q & ~tx_full;
    assign irq_rx = rie_q & rx_full_q;

endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic              ext_sel,
    input  logic              ref_tick,
    input  logic              ext_tick,
    input  logic [RATE_W-1:0] rate,
    output logic              half_tick
);

    logic [RATE_W-1:0] cnt_q;
    logic              src_tick;
    logic              wrap;

    assign src_tick  = ext_sel ? ext_tick : ref_tick;
    assign wrap      = (cnt_q == rate);
    assign half_tick = run & src_tick & wrap;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (run && src_tick)
            cnt_q <= wrap ? '0 : cnt_q + RATE_W'(1);
    end

endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  frame_cfg_t          cfg_in,
    input  logic                tx_full,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic                half_tick,
    input  logic                rxd,
    output logic                take,
    output logic                busy,
    output frame_cfg_t          cfg_act,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                sclk,
    output logic                txd,
    output logic                fsel_n
);

    logic [CNT_W-1:0]    hcnt_q, hnext, last_h;
    logic [MAX_BITS-1:0] tx_sh, rx_sh, load_word;
    logic [BITS_W-1:0]   n_act, n_in, pad;
    logic                act_now, act_next, lead_edge, trail_edge, rx_in;
    logic                do_sample, do_shift;

    assign take      = ~busy & tx_full;
    assign n_in      = frame_bits(cfg_in.size_m1);
    assign pad       = BITS_W'(MAX_BITS) - n_in;
    assign load_word = tx_word << pad;

    assign n_act  = frame_bits(cfg_act.size_m1);
    assign last_h = {n_act, 1'b1};
    assign hnext  = hcnt_q + CNT_W'(1);

    // Active half periods: phase 0 uses even halves from 2, phase 1 odd halves below the last.
    always_comb begin
        if (cfg_act.cpha)
            act_next = hnext[0] & (hnext < last_h);
        else
            act_next = ~hnext[0] & (hnext >= CNT_W'(2));
    end

    assign act_now    = sclk ^ cfg_act.cpol;
    assign lead_edge  = act_next & ~act_now;
    assign trail_edge = ~act_next & act_now;
    assign rx_in      = cfg_act.loopback ? txd : rxd;
    assign do_sample  = cfg_act.cpha ? trail_edge : lead_edge;
    assign do_shift   = cfg_act.cpha ? (lead_edge && hnext != CNT_W'(1)) : trail_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            hcnt_q  <= '0;
            sclk    <= 1'b0;
            txd     <= 1'b0;
            fsel_n  <= 1'b1;
            tx_sh   <= '0;
            rx_sh   <= '0;
            cfg_act <= '0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                sclk   <= cfg_in.cpol;
                fsel_n <= 1'b1;
                if (take) begin
                    busy    <= 1'b1;
                    cfg_act <= cfg_in;
                    hcnt_q  <= '0;
                    fsel_n  <= 1'b0;
                    tx_sh   <= load_word;
                    txd     <= load_word[MAX_BITS-1];
                    rx_sh   <= '0;
                end
            end else if (half_tick) begin
                if (hcnt_q == last_h) begin
                    busy    <= 1'b0;
                    fsel_n  <= 1'b1;
                    done    <= 1'b1;
                    rx_word <= rx_sh;
                    sclk    <= cfg_act.cpol;
                end else begin
                    hcnt_q <= hnext;
                    sclk   <= cfg_act.cpol ^ act_next;
                    if (do_sample)
                        rx_sh <= {rx_sh[MAX_BITS-2:0], rx_in};
                    if (do_shift) begin
                        tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
                        txd   <= tx_sh[MAX_BITS-2];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_master_port.sv
module spi_master_port
    import spi_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ref_tick,
    input  logic             ext_tick,
    input  logic             rxd,
    output logic             sclk,
    output logic             txd,
    output logic             fsel_n,
    output logic             irq_tx,
    output logic             irq_rx
);

    frame_cfg_t          cfg_live, cfg_act;
    logic                take, busy, done, half_tick, tx_full;
    logic [MAX_BITS-1:0] tx_word, rx_word;

    spi_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .take      (take),
        .done      (done),
        .busy      (busy),
        .rx_word   (rx_word),
        .cfg       (cfg_live),
        .tx_full   (tx_full),
        .tx_word   (tx_word),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx)
    );

    spi_port_clkdiv u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (take),
        .run       (busy),
        .ext_sel   (cfg_act.ext_sel),
        .ref_tick  (ref_tick),
        .ext_tick  (ext_tick),
        .rate      (cfg_act.rate),
        .half_tick (half_tick)
    );

    spi_port_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_live),
        .tx_full   (tx_full),
        .tx_word   (tx_word),
        .half_tick (half_tick),
        .rxd       (rxd),
        .take      (take),
        .busy      (busy),
        .cfg_act   (cfg_act),
        .done      (done),
        .rx_word   (rx_word),
        .sclk      (sclk),
        .txd       (txd),
        .fsel_n    (fsel_n)
    );

endmodule

// File: rtl/spi_master_port_chk.sv
module spi_master_port_chk
    import spi_port_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic       txd,
    input logic       fsel_n,
    input logic       half_tick,
    input logic       live_cpol,
    input frame_cfg_t cfg_act
);

    logic             sclk_d;
    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        sclk_d <= sclk;
        if (rst || fsel_n)
            edge_cnt <= '0;
        else if (sclk != sclk_d)
            edge_cnt <= edge_cnt + CNT_W'(1);
    end

    // R4: between frames sclk follows the programmed idle level
    p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
        (fsel_n && $past(fsel_n)) |-> (sclk == $past(live_cpol)));

    // R2: inside a frame sclk moves only on a divider half-period strobe
    p_sclk_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!fsel_n && $past(!fsel_n) && !$past(half_tick)) |-> $stable(sclk));

    // R6: serial data changes only together with a serial clock edge
    p_txd_with_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (!fsel_n && $past(!fsel_n) && $stable(sclk)) |-> $stable(txd));

    // R10: the settings of a running frame stay frozen
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (!fsel_n && $past(!fsel_n)) |-> $stable(cfg_act));

    // R5: every frame carries exactly 2N serial clock edges
    p_edge_count_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fsel_n) |-> (edge_cnt == {frame_bits(cfg_act.size_m1), 1'b0}));

endmodule

bind spi_master_port spi_master_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .txd       (txd),
    .fsel_n    (fsel_n),
    .half_tick (half_tick),
    .live_cpol (cfg_live.cpol),
    .cfg_act   (cfg_act)
);

// File: tb/tb_spi_master_port.sv
`timescale 1ns/1ps
module tb_spi_master_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ref_tick = 1'b1, ext_tick = 1'b0;
    logic        rxd = 1'b0;
    logic        sclk, txd, fsel_n, irq_tx, irq_rx;

    always #2.5 clk = ~clk;

    spi_master_port dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ref_tick(ref_tick), .ext_tick(ext_tick), .rxd(rxd),
        .sclk(sclk), .txd(txd), .fsel_n(fsel_n), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    int nchk = 0, nfail = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- serial monitor and slave model -----------------
    int          cyc = 0, t0 = 0, t_first = 0, t_last = 0, t_rise = -100;
    int          m_lead, m_trail, m_len, m_edges = 0, m_gap = 0, frames_done = 0;
    int          sl_idx = 0, m_n = 8;
    logic        m_cpol = 1'b0, m_cpha = 1'b0;
    logic [15:0] slave_word = 16'h0, cap = 16'h0;
    logic        prev_fsel = 1'b1, prev_sclk = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_fsel && !fsel_n) begin
            m_gap   = cyc - t_rise;
            t0      = cyc;
            m_edges = 0;
            cap     = 16'h0;
            sl_idx  = m_n - 1;
            rxd     = slave_word[sl_idx];
        end else if (!fsel_n && sclk != prev_sclk) begin
            m_edges = m_edges + 1;
            if (m_edges == 1) t_first = cyc;
            t_last = cyc;
            if ((sclk != m_cpol) != m_cpha) begin
                cap = {cap[14:0], txd};
            end else if (!(m_cpha && m_edges == 1)) begin
                sl_idx = sl_idx - 1;
                if (sl_idx >= 0) rxd = slave_word[sl_idx];
            end
        end
        if (!prev_fsel && fsel_n) begin
            t_rise  = cyc;
            m_lead  = t_first - t0;
            m_trail = cyc - t_last;
            m_len   = cyc - t0;
            frames_done = frames_done + 1;
        end
        prev_fsel = fsel_n;
        prev_sclk = sclk;
    end

    int ext_div = 0;
    initial forever begin
        @(negedge clk);
        ext_div  = ext_div + 1;
        ext_tick = (ext_div % 4 == 0);
    end

    // ---------------- register access -----------------
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic clr, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = clr;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames_done + n;
        for (int i = 0; i < 20000 && frames_done < target; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] ctrl_word(input logic ext, input logic [3:0] sz,
                                              input logic [7:0] rate);
        return {3'b000, ext, sz, rate};
    endfunction

    function automatic logic [15:0] mode_word(input logic cpha, input logic cpol,
                                              input logic lb, input logic tie,
                                              input logic rie);
        return {11'h0, cpha, cpol, lb, tie, rie};
    endfunction

    function automatic int nbits(input logic [3:0] sz);
        return (sz < 4'd3) ? 4 : int'(sz) + 1;
    endfunction

    // ---------------- vector table -----------------
    typedef struct packed {
        logic [7:0]  rate;
        logic [3:0]  sz;
        logic        cpol;
        logic        cpha;
        logic        lb;
        logic [15:0] tx;
        logic [15:0] sl;
        logic [15:0] ex;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 4'd7,  1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C, 16'h003C},
        '{8'd1, 4'd7,  1'b1, 1'b0, 1'b0, 16'h005A, 16'h00C3, 16'h00C3},
        '{8'd2, 4'd15, 1'b0, 1'b1, 1'b0, 16'hBEEF, 16'h1234, 16'h1234},
        '{8'd0, 4'd15, 1'b1, 1'b1, 1'b0, 16'h8001, 16'hF00F, 16'hF00F},
        '{8'd3, 4'd3,  1'b0, 1'b0, 1'b1, 16'hFFF9, 16'h0005, 16'h0009},
        '{8'd0, 4'd0,  1'b1, 1'b1, 1'b0, 16'h0006, 16'h000B, 16'h000B},
        '{8'd1, 4'd11, 1'b0, 1'b1, 1'b1, 16'h0ABC, 16'h0555, 16'h0ABC},
        '{8'd0, 4'd4,  1'b0, 1'b0, 1'b0, 16'h0015, 16'h000A, 16'h000A}
    };

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int n, h;
        logic [15:0] mask;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 fsel_n", int'(fsel_n), 1);
        chk("R1 sclk", int'(sclk), 0);
        chk("R1 txd", int'(txd), 0);
        chk("R1 irq_tx", int'(irq_tx), 0);
        chk("R1 irq_rx", int'(irq_rx), 0);
        rd(2'd0, 1'b0, d); chk("R1 CTRL", int'(d), 0);
        rd(2'd1, 1'b0, d); chk("R1 MODE", int'(d), 0);
        rd(2'd3, 1'b0, d); chk("R1 STAT", int'(d), 1);

        // R9: transmit interrupt follows its enable while the holding register is empty
        wr(2'd1, mode_word(0, 0, 0, 1, 0));
        @(negedge clk);
        chk("R9 irq_tx enabled", int'(irq_tx), 1);
        chk("R9 irq_rx disabled", int'(irq_rx), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            n    = nbits(VECS[v].sz);
            mask = 16'((32'd1 << n) - 1);
            h    = int'(VECS[v].rate) + 1;
            wr(2'd0, ctrl_word(1'b0, VECS[v].sz, VECS[v].rate));
            wr(2'd1, mode_word(VECS[v].cpha, VECS[v].cpol, VECS[v].lb, 1'b0, 1'b1));
            m_n = n; m_cpol = VECS[v].cpol; m_cpha = VECS[v].cpha;
            slave_word = VECS[v].sl;
            repeat (2) @(negedge clk);
            chk("R4 idle level", int'(sclk), int'(VECS[v].cpol));
            wr(2'd2, VECS[v].tx);
            wait_frames(1);
            chk("R2 frame length", m_len, (2 * n + 2) * h);
            chk("R5 lead", m_lead, VECS[v].cpha ? h : 2 * h);
            chk("R5 trail", m_trail, VECS[v].cpha ? 2 * h : h);
            chk("R5 edges", m_edges, 2 * n);
            chk("R6 msb-first txd", int'(cap), int'(VECS[v].tx & mask));
            @(negedge clk);
            chk("R9 irq_rx set", int'(irq_rx), 1);
            rd(2'd2, 1'b1, d);
            chk(VECS[v].lb ? "R8 loopback word" : "R7 received word", int'(d), int'(VECS[v].ex));
            @(negedge clk);
            chk("R9 irq_rx cleared", int'(irq_rx), 0);
        end

        // R3: external source, ref_tick still high every cycle
        wr(2'd0, ctrl_word(1'b1, 4'd7, 8'd1));
        wr(2'd1, mode_word(0, 0, 0, 0, 0));
        m_n = 8; m_cpol = 1'b0; m_cpha = 1'b0; slave_word = 16'h0096;
        repeat (2) @(negedge clk);
        rd(2'd0, 1'b0, d); chk("R3 CTRL readback", int'(d), 16'h1701);
        wr(2'd2, 16'h0071);
        wait_frames(1);
        chk("R3 half period from ext_tick", m_trail, 8);
        chk("R3 edges", m_edges, 16);
        @(negedge clk);
        rd(2'd2, 1'b1, d); chk("R3 received word", int'(d), 16'h0096);

        // R10: mid-frame rewrite of rate, size, polarity and phase
        wr(2'd0, ctrl_word(1'b0, 4'd7, 8'd0));
        wr(2'd1, mode_word(0, 0, 0, 0, 0));
        m_n = 8; m_cpol = 1'b0; m_cpha = 1'b0; slave_word = 16'h00E1;
        repeat (2) @(negedge clk);
        wr(2'd2, 16'h0033);
        repeat (2) @(negedge clk);
        wr(2'd0, ctrl_word(1'b0, 4'd3, 8'd3));
        wr(2'd1, mode_word(1, 1, 0, 0, 0));
        wait_frames(1);
        chk("R10 length unchanged", m_len, 18);
        chk("R10 edges unchanged", m_edges, 16);
        chk("R10 lead unchanged", m_lead, 2);
        chk("R10 data unchanged", int'(cap), 16'h0033);
        repeat (2) @(negedge clk);
        chk("R10 new idle level after frame", int'(sclk), 1);
        rd(2'd2, 1'b1, d); chk("R10 received word", int'(d), 16'h00E1);

        // R11: back-to-back frames
        wr(2'd0, ctrl_word(1'b0, 4'd7, 8'd0));
        wr(2'd1, mode_word(0, 0, 0, 0, 0));
        m_n = 8; m_cpol = 1'b0; m_cpha = 1'b0; slave_word = 16'h005C;
        repeat (2) @(negedge clk);
        wr(2'd2, 16'h00C6);
        wr(2'd2, 16'h0027);
        wait_frames(2);
        chk("R11 one-cycle gap", m_gap, 1);
        chk("R11 second word", int'(cap), 16'h0027);
        chk("R11 second length", m_len, 18);
        @(negedge clk);
        rd(2'd3, 1'b0, d); chk("R9 STAT after frames", int'(d), 16'h0003);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule